// File: doc/BRIEF.md
# Compact Branch Target Generator

This block works out the next program counter for branches and jumps that have no delay slot in a 64-bit core. Each cycle it may receive one instruction. That instruction comes with its current PC, the values of its two source operands, the index of its first source register, a two-bit class code, the raw 26-bit immediate field and a link flag. The block returns a redirect strobe and the next PC. For the linking forms it also returns a request to write the return address into register 31.

Four transfers are handled:
- An unconditional PC-relative branch with a 26-bit word offset, with or without a link.
- A shared class that does one of two things, chosen by the first source register index. When the index is non-zero, it is a branch-if-zero with a 21-bit word offset. When the index is zero, it is a jump to the second operand plus a 16-bit displacement.
- A register-based jump that takes the same displacement and may also link.

Since no delay slot follows, the instruction after a taken transfer must never run. The redirect strobe and the link request therefore arrive together, and the fetch logic can squash on the redirect alone. All results are registered and appear one clock after the instruction is presented.

Top module: `cbt_top`

## Requirements
- R1: While `rstN` is low, and on the first edge after it goes low, `redirect` and `linkWe` are 0 and `nextPc` is 0.
- R2: With class 2'b01, the unconditional branch sets `redirect`. Its `nextPc` is pc+4 plus `immField[25:0]`, sign-extended from bit 25 and shifted left by two.
- R3: With class 2'b01 and `linkFlag` set, `linkWe` is 1, `linkAddr` is pc+4 and `linkIdx` is 31. Without `linkFlag`, `linkWe` is 0.
- R4: With class 2'b10, a non-zero `rsIdx` and a `rsVal` of zero, the branch is taken. Its `nextPc` is pc+4 plus `immField[20:0]`, sign-extended from bit 20 and shifted left by two.
- R5: With class 2'b10, a non-zero `rsIdx` and a non-zero `rsVal`, `redirect` and `linkWe` both stay 0 and `nextPc` is pc+4.
- R6: With class 2'b10 and an `rsIdx` of zero, `redirect` is set and `nextPc` is `rtVal` plus `immField[15:0]`, sign-extended from bit 15. `linkWe` stays 0 whatever `linkFlag` holds.
- R7: With class 2'b11, `redirect` is set and `nextPc` is `rtVal` plus the sign-extended `immField[15:0]`. `linkWe` equals `linkFlag`, and when it is set `linkAddr` is pc+4.
- R8: With `issueValid` low or class 2'b00, `redirect` and `linkWe` are 0 and `nextPc` is pc+4. A link request never appears without a redirect in the same cycle.
- R9: Offsets with their top bit set, such as 26'h2000000 and 21'h100000, produce targets below pc+4, with correct wrap-around modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| issueValid | input | 1 | Instruction present this cycle |
| opClass | input | 2 | 00 none, 01 PC-relative branch, 10 zero-branch/indexed jump, 11 register jump |
| linkFlag | input | 1 | Link variant requested |
| pc | input | 64 | PC of the instruction |
| rsIdx | input | 5 | Index of the first source register |
| rsVal | input | 64 | Value of the first source operand |
| rtVal | input | 64 | Value of the second source operand |
| immField | input | 26 | Raw immediate bits of the instruction |
| nextPc | output | 64 | Next PC, registered |
| redirect | output | 1 | Control transfer taken, registered |
| linkWe | output | 1 | Return-address write request, registered |
| linkIdx | output | 5 | Destination register of the link write (31) |
| linkAddr | output | 64 | Return address (pc+4), registered |

## Verification
Every output is due exactly one rising edge after its instruction is presented. No result is carried into a later cycle. The bench drives each vector on the falling edge. It builds the expected next PC, redirect and link values with a behavioural model working on 64-bit integers. Just after the following rising edge, it compares all outputs against that expectation. Directed vectors cover each class, the rsIdx split on the shared class, and extreme offsets. These are followed by a run of pseudo-random vectors, each checked in the same single-edge slot.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    OpNone     = 2'b00,
    OpBranch   = 2'b01,
    OpZeroJump = 2'b10,
    OpRegJump  = 2'b11
  } opClassT;

  typedef struct packed {
    logic useLong;    // 26-bit word offset on pc+4
    logic useMid;     // 21-bit word offset on pc+4
    logic useRegBase; // rt plus 16-bit byte displacement
    logic takeIt;     // redirect this cycle
    logic linkIt;     // write return address
  } ctrlStrobesT;
endpackage

// File: rtl/cbt_ctrl.sv
module cbt_ctrl
  import cbt_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 issueValid,
  input  opClassT              opClass,
  input  logic [REG_IDX_W-1:0] rsIdx,
  input  logic                 linkFlag,
  input  logic                 rsIsZero,
  output ctrlStrobesT          strobes
);
  logic rsFieldZero;
  assign rsFieldZero = (rsIdx == '0);

  always_comb begin
    strobes = '0;
    if (issueValid) begin
      unique case (opClass)
        OpBranch: begin
          strobes.useLong = 1'b1;
          strobes.takeIt  = 1'b1;
          strobes.linkIt  = linkFlag;
        end
        OpZeroJump: begin
          if (rsFieldZero) begin
            strobes.useRegBase = 1'b1;
            strobes.takeIt     = 1'b1;
          end else begin
            strobes.useMid = 1'b1;
            strobes.takeIt = rsIsZero;
          end
        end
        OpRegJump: begin
          strobes.useRegBase = 1'b1;
          strobes.takeIt     = 1'b1;
          strobes.linkIt     = linkFlag;
        end
        default: strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/cbt_datapath.sv
module cbt_datapath
  import cbt_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int IMM_W     = 26,
  parameter int MID_W     = 21,
  parameter int SHORT_W   = 16,
  parameter int INSTR_BYT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobesT      strobes,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  input  logic [IMM_W-1:0] immField,
  output logic             rsIsZero,
  output logic [XLEN-1:0]  nextPc,
  output logic             redirect,
  output logic             linkWe,
  output logic [XLEN-1:0]  linkAddr
);
  localparam int WORD_SH = $clog2(INSTR_BYT);

  logic [XLEN-1:0] pcPlusStep;
  logic [XLEN-1:0] longOff;
  logic [XLEN-1:0] midOff;
  logic [XLEN-1:0] shortOff;
  logic [XLEN-1:0] baseSel;
  logic [XLEN-1:0] offSel;
  logic [XLEN-1:0] target;

  assign rsIsZero   = (rsVal == '0);
  assign pcPlusStep = pc + XLEN'(INSTR_BYT);

  assign longOff  = {{(XLEN-IMM_W){immField[IMM_W-1]}}, immField} << WORD_SH;
  assign midOff   = {{(XLEN-MID_W){immField[MID_W-1]}}, immField[MID_W-1:0]} << WORD_SH;
  assign shortOff = {{(XLEN-SHORT_W){immField[SHORT_W-1]}}, immField[SHORT_W-1:0]};

  always_comb begin
    baseSel = strobes.useRegBase ? rtVal : pcPlusStep;
    if (strobes.useLong)      offSel = longOff;
    else if (strobes.useMid)  offSel = midOff;
    else                      offSel = shortOff;
    target = baseSel + offSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc   <= '0;
      redirect <= 1'b0;
      linkWe   <= 1'b0;
      linkAddr <= '0;
    end else begin
      nextPc   <= strobes.takeIt ? target : pcPlusStep;
      redirect <= strobes.takeIt;
      linkWe   <= strobes.linkIt & strobes.takeIt;
      linkAddr <= pcPlusStep;
    end
  end
endmodule

// File: rtl/cbt_top.sv
module cbt_top #(
  parameter int XLEN      = 64,
  parameter int IMM_W     = 26,
  parameter int MID_W     = 21,
  parameter int SHORT_W   = 16,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [1:0]           opClass,
  input  logic                 linkFlag,
  input  logic [XLEN-1:0]      pc,
  input  logic [REG_IDX_W-1:0] rsIdx,
  input  logic [XLEN-1:0]      rsVal,
  input  logic [XLEN-1:0]      rtVal,
  input  logic [IMM_W-1:0]     immField,
  output logic [XLEN-1:0]      nextPc,
  output logic                 redirect,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkIdx,
  output logic [XLEN-1:0]      linkAddr
);
  import cbt_pkg::*;

  ctrlStrobesT strobes;
  logic        rsIsZero;

  assign linkIdx = REG_IDX_W'(LINK_REG);

  cbt_ctrl #(.REG_IDX_W(REG_IDX_W)) u_ctrl (
    .issueValid (issueValid),
    .opClass    (opClassT'(opClass)),
    .rsIdx      (rsIdx),
    .linkFlag   (linkFlag),
    .rsIsZero   (rsIsZero),
    .strobes    (strobes)
  );

  cbt_datapath #(
    .XLEN(XLEN), .IMM_W(IMM_W), .MID_W(MID_W), .SHORT_W(SHORT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pc       (pc),
    .rsVal    (rsVal),
    .rtVal    (rtVal),
    .immField (immField),
    .rsIsZero (rsIsZero),
    .nextPc   (nextPc),
    .redirect (redirect),
    .linkWe   (linkWe),
    .linkAddr (linkAddr)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
  parameter int XLEN      = 64,
  parameter int IMM_W     = 26,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueValid,
  input logic [1:0]           opClass,
  input logic                 linkFlag,
  input logic [XLEN-1:0]      pc,
  input logic [REG_IDX_W-1:0] rsIdx,
  input logic [XLEN-1:0]      rsVal,
  input logic [XLEN-1:0]      rtVal,
  input logic [IMM_W-1:0]     immField,
  input logic [XLEN-1:0]      nextPc,
  input logic                 redirect,
  input logic                 linkWe,
  input logic [XLEN-1:0]      linkAddr
);
  logic [XLEN-1:0] dispShort;
  assign dispShort = {{(XLEN-16){immField[15]}}, immField[15:0]};

  // R8: a link request always comes with a redirect
  a_r8_link_needs_redirect: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> redirect);

  // R8: idle cycles never redirect
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (!redirect && !linkWe));

  // R3: linking branch writes pc+4
  a_r3_link_addr: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && opClass == 2'b01 && linkFlag) |=>
      (linkWe && linkAddr == $past(pc) + 64'd4));

  // R5: non-zero operand falls through
  a_r5_fall_through: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && opClass == 2'b10 && rsIdx != '0 && rsVal != '0) |=>
      (!redirect && !linkWe && nextPc == $past(pc) + 64'd4));

  // R7: register jump target
  a_r7_reg_target: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && opClass == 2'b11) |=>
      (redirect && nextPc == $past(rtVal) + $past(dispShort) && linkWe == $past(linkFlag)));

  // R6: indexed jump on shared class never links
  a_r6_no_link: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && opClass == 2'b10 && rsIdx == '0) |=> (redirect && !linkWe));
endmodule

bind cbt_top cbt_checker #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_IDX_W(REG_IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .opClass(opClass),
  .linkFlag(linkFlag), .pc(pc), .rsIdx(rsIdx), .rsVal(rsVal), .rtVal(rtVal),
  .immField(immField), .nextPc(nextPc), .redirect(redirect), .linkWe(linkWe),
  .linkAddr(linkAddr)
);

// File: tb/sim_cbt_top.sv
module sim_cbt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [1:0]  opClass = 2'b00;
  logic        linkFlag = 1'b0;
  logic [63:0] pc = '0;
  logic [4:0]  rsIdx = '0;
  logic [63:0] rsVal = '0;
  logic [63:0] rtVal = '0;
  logic [25:0] immField = '0;
  logic [63:0] nextPc;
  logic        redirect;
  logic        linkWe;
  logic [4:0]  linkIdx;
  logic [63:0] linkAddr;

  int vecCount = 0;
  int failCount = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cbt_top u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opClass(opClass),
    .linkFlag(linkFlag), .pc(pc), .rsIdx(rsIdx), .rsVal(rsVal), .rtVal(rtVal),
    .immField(immField), .nextPc(nextPc), .redirect(redirect), .linkWe(linkWe),
    .linkIdx(linkIdx), .linkAddr(linkAddr)
  );

  function automatic longint sext(input longint v, input int bits);
    longint sh = 64 - bits;
    return (v <<< sh) >>> sh;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic applyVec(input string tag, input bit v, input logic [1:0] cls, input bit lf,
                          input longint p, input int ri, input longint rs, input longint rt,
                          input logic [25:0] im);
    longint expPc, step;
    bit expRed, expLink;
    @(negedge clk);
    issueValid = v; opClass = cls; linkFlag = lf; pc = p; rsIdx = 5'(ri);
    rsVal = rs; rtVal = rt; immField = im;
    step = p + 4;
    expRed = 0; expLink = 0; expPc = step;
    if (v) begin
      if (cls == 2'b01) begin
        expRed = 1; expLink = lf; expPc = step + (sext(longint'(im), 26) * 4);
      end else if (cls == 2'b10) begin
        if (ri != 0) begin
          if (rs == 0) begin expRed = 1; expPc = step + (sext(longint'(im[20:0]), 21) * 4); end
        end else begin
          expRed = 1; expPc = rt + sext(longint'(im[15:0]), 16);
        end
      end else if (cls == 2'b11) begin
        expRed = 1; expLink = lf; expPc = rt + sext(longint'(im[15:0]), 16);
      end
    end
    @(posedge clk); #1;
    chk(tag, "redirect", longint'(redirect), longint'(expRed));
    chk(tag, "linkWe", longint'(linkWe), longint'(expLink));
    chk(tag, "nextPc", nextPc, expPc);
    if (expLink) begin
      chk(tag, "linkAddr", linkAddr, step);
      chk(tag, "linkIdx", longint'(linkIdx), 31);
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "redirect", longint'(redirect), 0);
    chk("R1", "linkWe", longint'(linkWe), 0);
    chk("R1", "nextPc", nextPc, 0);
    @(negedge clk); rstN = 1'b1;

    applyVec("R2", 1, 2'b01, 0, 64'h1000, 3, 5, 0, 26'h0000010);
    applyVec("R3", 1, 2'b01, 1, 64'h2000, 0, 0, 0, 26'h0000100);
    applyVec("R4", 1, 2'b10, 0, 64'h3000, 7, 0, 9, 26'h0000020);
    applyVec("R5", 1, 2'b10, 1, 64'h3000, 7, 1, 9, 26'h0000020);
    applyVec("R6", 1, 2'b10, 1, 64'h4000, 0, 0, 64'h8000, 26'h000fff0);
    applyVec("R6", 1, 2'b10, 0, 64'h4000, 0, 3, 64'h8000, 26'h0000044);
    applyVec("R7", 1, 2'b11, 1, 64'h5000, 2, 0, 64'hA000, 26'h0000008);
    applyVec("R7", 1, 2'b11, 0, 64'h5000, 2, 0, 64'hA000, 26'h0008000);
    applyVec("R8", 0, 2'b01, 1, 64'h6000, 1, 0, 0, 26'h0000004);
    applyVec("R8", 1, 2'b00, 1, 64'h6000, 1, 0, 0, 26'h0000004);
    applyVec("R9", 1, 2'b01, 0, 64'h10, 0, 0, 0, 26'h2000000);
    applyVec("R9", 1, 2'b10, 0, 64'h100, 4, 0, 0, 26'h0100000);
    applyVec("R9", 1, 2'b11, 1, 64'h0, 0, 0, 64'h4, 26'h3ffff80);
    for (int i = 0; i < 400; i++) begin
      longint rs = (($urandom % 3) == 0) ? 64'd0 : {$urandom, $urandom};
      applyVec("R2..R8 random", $urandom % 4 != 0, 2'($urandom), 1'($urandom),
               {$urandom, $urandom}, int'($urandom % 4), rs,
               {$urandom, $urandom}, 26'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule